// File: doc/BRIEF.md
# Variable-Length Bus Cycle Controller

This block paces each bus cycle of an 8-bit processor from a single fast base clock. A cycle opens with a first phase of fixed length and then enters a second phase. The second phase lasts at least a programmed minimum and is stretched for as long as the addressed target has not reported ready. A memory request goes out on the second tick of the first phase, as soon as the cycle's address has been captured, rather than waiting for the second phase.

An external opcode monitor supplies per-cycle hints. A cycle flagged as needing no memory closes at the minimum length. A cycle flagged as the idle second cycle of a one-byte instruction also closes at the minimum length, and it uses the free memory to read ahead at the already-known address of the next opcode. When the next opcode fetch asks for exactly that address, the held byte is returned and no new request is made. On any other access the read-ahead is discarded and a normal stretched cycle follows. A stop input holds the sequence at the end of the first phase so that fault logic can intervene.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: With `stop` low, `phi1` stays high for exactly P1_TICKS base ticks in every cycle.
- R2: `phi2` stays high for at least P2_MIN base ticks in every cycle.
- R3: In a cycle that uses memory, `phi2` ends exactly max(P2_MIN, r + 2 - s) ticks after it began, where s is the first `phi2` tick and r is the tick in which `mem_ready` answered that cycle's own request. A read returns `mem_rdata` of that answer on `cpu_rdata` by the first tick of the next cycle.
- R4: When memory is idle, an ordinary cycle raises `mem_start` for one tick on the second `phi1` tick, with `mem_addr`, `mem_rnw` and `mem_wdata` equal to the cycle's `cpu_addr`, `cpu_rnw` and `cpu_wdata`.
- R5: A cycle with `hint_no_mem` high issues no memory request, and its `phi2` lasts exactly P2_MIN ticks.
- R6: A cycle with `hint_one_byte` high has a `phi2` of exactly P2_MIN ticks. When memory is idle it raises `mem_start` on the second `phi1` tick as a read (`mem_rnw` = 1) at `hint_next_addr`.
- R7: An opcode fetch (`hint_opfetch` high, read) at the read-ahead address issues no new request. It returns the read-ahead byte and its `phi2` follows the R3 formula, with r taken as the tick in which the read-ahead was answered.
- R8: An opcode fetch at any other address drops the read-ahead. It issues its own request only after any request still outstanding has been answered, and it returns the data of its own address. At most one request is ever outstanding.
- R9: While `stop` is high at the end of the first phase, `phi1` stays high and `phi2` stays low. The phase lasts until the tick in which `stop` is seen low.
- R10: While `rst` is high, `phi1` = 1, `phi2` = 0 and `mem_start` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | Hold at end of first phase |
| cpu_addr | input | ADDR_W | Processor address for the cycle |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | DATA_W | Processor write data |
| hint_no_mem | input | 1 | Cycle needs no memory |
| hint_one_byte | input | 1 | Idle second cycle of a one-byte instruction |
| hint_opfetch | input | 1 | Cycle is an opcode fetch |
| hint_next_addr | input | ADDR_W | Known address of the next opcode |
| cpu_rdata | output | DATA_W | Read data returned to the processor |
| phi1 | output | 1 | First phase active |
| phi2 | output | 1 | Second phase active |
| mem_start | output | 1 | One-tick memory request strobe |
| mem_addr | output | ADDR_W | Memory request address |
| mem_rnw | output | 1 | Memory request direction |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | One-tick memory completion strobe |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |

## Verification
The bench builds the block with P1_TICKS = 3 and P2_MIN = 2, so a full cycle is only a handful of ticks long. With those values, memory latencies swept from 0 to 6 ticks land a reply before, exactly at, and well after the minimum second phase. For each latency the same sequence of ordinary reads and writes, no-memory cycles, read-ahead hits and misses, and a stopped cycle is run. Every cycle length is compared with the arithmetic max(P2_MIN, r + 2 - s). At long latencies the miss case has a read-ahead still in flight, and that brings the single-outstanding rule within reach.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic {PH_ONE, PH_TWO} phase_t;
  typedef enum logic [1:0] {CM_NORMAL, CM_SKIP, CM_HIT} cmode_t;
endpackage

// File: rtl/bcc_phase_timer.sv
module bcc_phase_timer
  import bcc_pkg::*;
#(
  parameter int P1_TICKS = 16,
  parameter int P2_MIN   = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic done_ok,
  output logic phi1,
  output logic phi2,
  output logic cyc_start,
  output logic p2_at_min
);
  localparam int MAXT  = (P1_TICKS > P2_MIN) ? P1_TICKS : P2_MIN;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] P1_LAST = CNT_W'(P1_TICKS - 1);
  localparam logic [CNT_W-1:0] P2_LAST = CNT_W'(P2_MIN - 1);

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic             p1_end;
  logic             min_ok;

  assign p1_end = (ph == PH_ONE) && (cnt == P1_LAST);
  assign min_ok = (ph == PH_TWO) && (cnt == P2_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_ONE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_ONE: begin
          if (p1_end) begin
            if (!stop) begin
              ph  <= PH_TWO;
              cnt <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (min_ok && done_ok) begin
            ph  <= PH_ONE;
            cnt <= '0;
          end else if (!min_ok) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign phi1      = (ph == PH_ONE);
  assign phi2      = (ph == PH_TWO);
  assign cyc_start = (ph == PH_ONE) && (cnt == '0);
  assign p2_at_min = min_ok;

  // R9: a held stop keeps the sequence parked at the end of phase one
  a_r9_stop_freeze: assert property (@(posedge clk) disable iff (rst)
    (p1_end && stop) |=> (phi1 && !phi2 && cnt == P1_LAST));

  // R2: phase two cannot end before its minimum count is reached
  a_r2_p2_floor: assert property (@(posedge clk) disable iff (rst)
    (phi2 && !min_ok) |=> phi2);
endmodule

// File: rtl/bcc_mem_port.sv
module bcc_mem_port
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rnw,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              hint_no_mem,
  input  logic              hint_one_byte,
  input  logic              hint_opfetch,
  input  logic [ADDR_W-1:0] hint_next_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rnw,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done_ok,
  output logic              skip_mode
);
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rnw;
    logic [DATA_W-1:0] wdata;
    logic              ahead;
  } req_t;

  cmode_t            mode, mode_n;
  logic              cur_done;
  logic              busy, out_ahead, out_drop;
  logic              req_pend;
  req_t              req_q, nr, src;
  logic              hit_c, nr_valid, use_nr, src_valid, issue;
  logic              ra_valid, ra_have;
  logic [ADDR_W-1:0] ra_addr;
  logic [DATA_W-1:0] ra_data;
  logic              start_q, rnw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_comb begin
    hit_c = hint_opfetch && cpu_rnw && !hint_no_mem && !hint_one_byte &&
            ra_valid && (cpu_addr == ra_addr);
    if (hint_one_byte) begin
      nr       = '{addr: hint_next_addr, rnw: 1'b1, wdata: '0, ahead: 1'b1};
      nr_valid = 1'b1;
      mode_n   = CM_SKIP;
    end else begin
      nr       = '{addr: cpu_addr, rnw: cpu_rnw, wdata: cpu_wdata, ahead: 1'b0};
      nr_valid = !hint_no_mem && !hit_c;
      mode_n   = hint_no_mem ? CM_SKIP : (hit_c ? CM_HIT : CM_NORMAL);
    end
    use_nr    = cyc_start && nr_valid;
    src       = use_nr ? nr : req_q;
    src_valid = use_nr || req_pend;
    issue     = src_valid && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= CM_NORMAL;
      cur_done  <= 1'b0;
      busy      <= 1'b0;
      out_ahead <= 1'b0;
      out_drop  <= 1'b0;
      req_pend  <= 1'b0;
      req_q     <= '0;
      ra_valid  <= 1'b0;
      ra_have   <= 1'b0;
      ra_addr   <= '0;
      ra_data   <= '0;
      start_q   <= 1'b0;
      addr_q    <= '0;
      rnw_q     <= 1'b1;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      start_q <= 1'b0;
      // completion of the outstanding request
      if (busy && mem_ready) begin
        busy <= 1'b0;
        if (!out_drop) begin
          if (out_ahead) begin
            ra_have <= 1'b1;
            ra_data <= mem_rdata;
          end else begin
            cur_done <= 1'b1;
            if (rnw_q) rdata_q <= mem_rdata;
          end
        end
      end
      if (mode == CM_HIT && ra_have) rdata_q <= ra_data;
      // per-cycle capture of hints
      if (cyc_start) begin
        mode     <= mode_n;
        cur_done <= 1'b0;
        if (hint_one_byte) begin
          ra_valid <= 1'b1;
          ra_addr  <= hint_next_addr;
          ra_have  <= 1'b0;
        end else if (hit_c) begin
          ra_valid <= 1'b0;
        end else if (!hint_no_mem) begin
          ra_valid <= 1'b0;
          ra_have  <= 1'b0;
        end
        if (busy && out_ahead && !hit_c && (hint_one_byte || !hint_no_mem))
          out_drop <= 1'b1;
      end
      if (issue) begin
        start_q   <= 1'b1;
        addr_q    <= src.addr;
        rnw_q     <= src.rnw;
        wdata_q   <= src.wdata;
        busy      <= 1'b1;
        out_ahead <= src.ahead;
        out_drop  <= 1'b0;
      end
      if (use_nr) begin
        req_q    <= nr;
        req_pend <= !issue;
      end else if (issue) begin
        req_pend <= 1'b0;
      end
    end
  end

  assign done_ok   = (mode == CM_SKIP) ||
                     (mode == CM_HIT && ra_have) ||
                     (mode == CM_NORMAL && cur_done);
  assign skip_mode = (mode == CM_SKIP);
  assign cpu_rdata = rdata_q;
  assign mem_start = start_q;
  assign mem_addr  = addr_q;
  assign mem_rnw   = rnw_q;
  assign mem_wdata = wdata_q;

  // R8: no new request while one is still unanswered
  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_ready) |=> !start_q);

  // R7: a read-ahead hit never launches a request of its own
  a_r7_hit_no_own_req: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_HIT) |-> !(start_q && !out_ahead));
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int P1_TICKS = 16,
  parameter int P2_MIN   = 12,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rnw,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              hint_no_mem,
  input  logic              hint_one_byte,
  input  logic              hint_opfetch,
  input  logic [ADDR_W-1:0] hint_next_addr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              phi1,
  output logic              phi2,
  output logic              mem_start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rnw,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic done_ok, cyc_start, p2_at_min, skip_mode;

  bcc_phase_timer #(
    .P1_TICKS(P1_TICKS),
    .P2_MIN  (P2_MIN)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .stop     (stop),
    .done_ok  (done_ok),
    .phi1     (phi1),
    .phi2     (phi2),
    .cyc_start(cyc_start),
    .p2_at_min(p2_at_min)
  );

  bcc_mem_port #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_port (
    .clk           (clk),
    .rst           (rst),
    .cyc_start     (cyc_start),
    .cpu_addr      (cpu_addr),
    .cpu_rnw       (cpu_rnw),
    .cpu_wdata     (cpu_wdata),
    .hint_no_mem   (hint_no_mem),
    .hint_one_byte (hint_one_byte),
    .hint_opfetch  (hint_opfetch),
    .hint_next_addr(hint_next_addr),
    .mem_ready     (mem_ready),
    .mem_rdata     (mem_rdata),
    .cpu_rdata     (cpu_rdata),
    .mem_start     (mem_start),
    .mem_addr      (mem_addr),
    .mem_rnw       (mem_rnw),
    .mem_wdata     (mem_wdata),
    .done_ok       (done_ok),
    .skip_mode     (skip_mode)
  );

  // R3: a cycle only closes once the port has declared it complete
  a_r3_end_needs_done: assert property (@(posedge clk) disable iff (rst)
    $rose(phi1) |-> $past(done_ok));

  // R5: flagged cycles close as soon as the minimum is reached
  a_r5_skip_at_min: assert property (@(posedge clk) disable iff (rst)
    (skip_mode && p2_at_min) |=> phi1);
endmodule

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;
  localparam int P1 = 3;
  localparam int P2M = 2;
  localparam int K_NORM = 0, K_NOMEM = 1, K_DUMMY = 2, K_HIT = 3, K_MISS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stop = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rnw = 1'b1;
  logic [7:0]  cpu_wdata = '0;
  logic        hint_no_mem = 1'b0, hint_one_byte = 1'b0, hint_opfetch = 1'b0;
  logic [15:0] hint_next_addr = '0;
  logic [7:0]  cpu_rdata;
  logic        phi1, phi2, mem_start, mem_rnw;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ready = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int n_cmp = 0, n_bad = 0;
  int tick = 0;
  int lat = 0;
  int st_tick = -100, rd_tick = -1;
  logic [15:0] st_addr = '0;
  logic        st_rnw = 1'b1;
  logic [7:0]  st_wd = '0;
  bit          done_run = 1'b0;

  always #4 clk = ~clk;

  bus_cycle_ctrl #(.P1_TICKS(P1), .P2_MIN(P2M), .ADDR_W(16), .DATA_W(8)) dut (
    .clk(clk), .rst(rst), .stop(stop), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
    .cpu_wdata(cpu_wdata), .hint_no_mem(hint_no_mem), .hint_one_byte(hint_one_byte),
    .hint_opfetch(hint_opfetch), .hint_next_addr(hint_next_addr), .cpu_rdata(cpu_rdata),
    .phi1(phi1), .phi2(phi2), .mem_start(mem_start), .mem_addr(mem_addr),
    .mem_rnw(mem_rnw), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] fdat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: answers each request lat ticks after its strobe
  int          m_cd = 0;
  bit          m_pend = 1'b0;
  logic [15:0] m_a = '0;
  always @(posedge clk) begin
    #2;
    mem_ready = 1'b0;
    if (mem_start) begin
      m_pend = 1'b1;
      m_a    = mem_addr;
      m_cd   = lat;
    end
    if (m_pend) begin
      if (m_cd == 0) begin
        mem_ready = 1'b1;
        mem_rdata = fdat(m_a);
        m_pend    = 1'b0;
      end else begin
        m_cd = m_cd - 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic observe();
    tick++;
    if (mem_start) begin
      st_tick = tick;
      st_addr = mem_addr;
      st_rnw  = mem_rnw;
      st_wd   = mem_wdata;
      rd_tick = -1;
    end
    if (mem_ready && rd_tick < 0) rd_tick = tick;
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_cycle(input int kind, input logic [15:0] a, input logic rnw,
                           input logic [7:0] wd, input logic [15:0] nxt, input int hold);
    int  t0, p1, p2, s;
    bit  in_p2;
    cpu_addr       = a;
    cpu_rnw        = rnw;
    cpu_wdata      = wd;
    hint_no_mem    = (kind == K_NOMEM);
    hint_one_byte  = (kind == K_DUMMY);
    hint_opfetch   = (kind == K_HIT || kind == K_MISS);
    hint_next_addr = nxt;
    stop           = (hold > 0);
    t0 = tick; p1 = 1; p2 = 0; s = 0; in_p2 = 1'b0;
    forever begin
      @(negedge clk);
      observe();
      if (phi1 && in_p2) break;
      if (phi1) begin
        p1++;
        if (hold > 0 && p1 == hold) stop = 1'b0;
        if (p1 > 200) break;
      end else begin
        if (!in_p2) begin
          in_p2 = 1'b1;
          s = tick;
        end
        p2++;
        if (p2 > 200) break;
      end
    end
    if (hold > 0) chk("R9 stopped phase-one length", p1, hold);
    else          chk("R1 phase-one length", p1, P1);
    chk("R2 phase-two floor", int'(p2 >= P2M), 1);
    case (kind)
      K_NORM: begin
        chk("R4 strobe on second tick", st_tick, t0 + 1);
        chk("R4 request address", int'(st_addr), int'(a));
        chk("R4 request direction", int'(st_rnw), int'(rnw));
        if (!rnw) chk("R4 request write data", int'(st_wd), int'(wd));
        chk("R3 phase-two length", p2, maxi(P2M, rd_tick + 2 - s));
        if (rnw) chk("R3 read data", int'(cpu_rdata), int'(fdat(a)));
      end
      K_NOMEM: begin
        chk("R5 no request", int'(st_tick < t0), 1);
        chk("R5 phase-two at minimum", p2, P2M);
      end
      K_DUMMY: begin
        chk("R6 read-ahead strobe tick", st_tick, t0 + 1);
        chk("R6 read-ahead address", int'(st_addr), int'(nxt));
        chk("R6 read-ahead is a read", int'(st_rnw), 1);
        chk("R6 phase-two at minimum", p2, P2M);
      end
      K_HIT: begin
        chk("R7 no new request", int'(st_tick < t0), 1);
        chk("R7 answered address", int'(st_addr), int'(a));
        chk("R7 phase-two length", p2, maxi(P2M, rd_tick + 2 - s));
        chk("R7 read-ahead data", int'(cpu_rdata), int'(fdat(a)));
      end
      default: begin
        chk("R8 own request issued", int'(st_tick > t0), 1);
        chk("R8 own request address", int'(st_addr), int'(a));
        chk("R8 phase-two length", p2, maxi(P2M, rd_tick + 2 - s));
        chk("R8 own data", int'(cpu_rdata), int'(fdat(a)));
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset phi1", int'(phi1), 1);
    chk("R10 reset phi2", int'(phi2), 0);
    chk("R10 reset mem_start", int'(mem_start), 0);
    rst = 1'b0;
    for (int l = 0; l <= 6; l++) begin
      logic [15:0] b;
      lat = l;
      b = 16'h1200 + 16'(l * 16);
      run_cycle(K_NORM,  b + 16'd1,  1'b1, 8'h00,            16'h0,      0);
      run_cycle(K_NORM,  b + 16'd2,  1'b0, 8'hC3 ^ 8'(l),    16'h0,      0);
      run_cycle(K_NOMEM, b + 16'd3,  1'b1, 8'h00,            16'h0,      0);
      run_cycle(K_NORM,  b + 16'd4,  1'b1, 8'h00,            16'h0,      0);
      run_cycle(K_DUMMY, b + 16'd4,  1'b1, 8'h00,            b + 16'd5,  0);
      run_cycle(K_HIT,   b + 16'd5,  1'b1, 8'h00,            16'h0,      0);
      run_cycle(K_DUMMY, b + 16'd7,  1'b1, 8'h00,            b + 16'd8,  0);
      run_cycle(K_MISS,  b + 16'd9,  1'b1, 8'h00,            16'h0,      0);
      run_cycle(K_NORM,  b + 16'd10, 1'b1, 8'h00,            16'h0,      P1 + 2 + (l % 3));
    end
    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule